// File: doc/BRIEF.md
# Auxiliary Memory Bank Router

This block holds the eight memory-management mode flags of a small 8-bit computer and routes each 16-bit CPU access. An access below $C000 goes either to the main 48K RAM or to the auxiliary 48K RAM. An access in $C100-$CFFE is served by the internal firmware ROM or by peripheral slot ROM. An access to $C013-$C018 returns one flag as a status byte. The block drives a bank select, a device select and a read-data multiplexer. The multiplexer picks between the RAM, ROM and slot data that come in from outside and the status byte the block builds itself.

Software changes the flags by writing to the sixteen addresses $C000-$C00F. A write to the even address of a pair clears that pair's flag and a write to the odd address sets it. The write data is not used. Two display-page inputs, `page2` and `hires`, come from a separate video-switch block. They take part in the routing of the text and hi-res display pages when the 80-column store mode is on. Accesses to $C000-$C0FF outside the status window, to $CFFF and to $D000-$FFFF are not claimed by this block.

Top module: `aux_bank_router`

## Requirements
- R1: The flags change only on a clock edge on which `busValid` and `busWrite` are high and `busAddr` lies in $C000-$C00F. The written flag has index `busAddr[3:1]` and takes the value of `busAddr[0]`. `flagsOut` bit 0 is store80, bit 1 is ramRd, bit 2 is ramWrt, bit 3 is intCx, bit 4 is altZp, bit 5 is slotC3, bit 6 is col80 and bit 7 is altChar.
- R2: For $0000-$01FF, `bankAux` equals altZp on both reads and writes, whatever ramRd and ramWrt hold.
- R3: For the rest of $0200-$BFFF, when no 80-column override applies, a read has `bankAux` = ramRd and a write has `bankAux` = ramWrt.
- R4: For $0400-$07FF with store80 set, `bankAux` equals `page2` on reads and on writes.
- R5: For $2000-$3FFF with store80 set, `bankAux` is 1 only when `page2` and `hires` are both 1.
- R6: A read of $C100-$CFFE selects internal ROM (devSel 2) when intCx is set. It also selects internal ROM when slotC3 is clear and the address is in $C300-$C3FF or $C800-$CFFE. In every other case it selects slot ROM (devSel 3).
- R7: A write to $C100-$CFFE is ignored: devSel is 0 (none) and no flag changes.
- R8: A read of $C013, $C014, $C015, $C016, $C017 or $C018 gives devSel 4 and returns ramRd, ramWrt, intCx, altZp, slotC3 or store80 respectively in bit 7 of `rdData`, with bits 6:0 zero.
- R9: After reset all flags are zero.
- R10: devSel is 1 (RAM) for every valid access below $C000 and 0 for every other case not covered by R6 or R8, including `busValid` low. `bankAux` is 0 whenever devSel is not 1.
- R11: `rdData` is `auxData` or `mainData` on a RAM read, chosen by `bankAux`. It is `romData` for devSel 2 and `slotData` for devSel 3. On a write or when devSel is 0 it is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| busValid | input | 1 | An access is present this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 16 | CPU address |
| page2 | input | 1 | Display page 2 selected (from video switches) |
| hires | input | 1 | Hi-res graphics selected (from video switches) |
| mainData | input | 8 | Read data from main RAM |
| auxData | input | 8 | Read data from auxiliary RAM |
| romData | input | 8 | Read data from internal ROM |
| slotData | input | 8 | Read data from slot ROM |
| bankAux | output | 1 | RAM access targets auxiliary bank |
| devSel | output | 3 | 0 none, 1 RAM, 2 internal ROM, 3 slot ROM, 4 status |
| rdData | output | 8 | Multiplexed read data |
| flagsOut | output | 8 | Current flags, bit order as in R1 |

## Verification
The main stimulus is a sweep. Every combination of the six routing flags, together with all four `page2`/`hires` settings, is applied to boundary addresses of each region, and each address is both read and written. The read/write pairs show whether the separate read and write bank flags are used. The edge addresses $01FF/$0200, $07FF/$0800 and $3FFF/$4000 show whether each override window ends at the right place. The $C300 and $C800 probes, swept against slotC3 and intCx, separate the two ROM-priority rules from each other. Status reads under the same flag patterns show whether each flag sits at its own status address.

// File: rtl/router_pkg.sv
package router_pkg;
  localparam int ADDR_W    = 16;
  localparam int DATA_W    = 8;
  localparam int NUM_FLAGS = 8;
  localparam int FIDX_W    = $clog2(NUM_FLAGS);

  // flag indices; write address pair order depends on these
  localparam int F_STORE80 = 0;
  localparam int F_RAMRD   = 1;
  localparam int F_RAMWRT  = 2;
  localparam int F_INTCX   = 3;
  localparam int F_ALTZP   = 4;
  localparam int F_SLOTC3  = 5;

  typedef enum logic [2:0] {
    DEV_NONE = 3'd0,
    DEV_RAM  = 3'd1,
    DEV_IROM = 3'd2,
    DEV_SLOT = 3'd3,
    DEV_STAT = 3'd4
  } devSel_t;

  typedef struct packed {
    logic              flagWe;
    logic [FIDX_W-1:0] flagIdx;
    logic              flagVal;
  } swStrobe_t;
endpackage

// File: rtl/router_ctrl.sv
module router_ctrl
  import router_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  output swStrobe_t         strobe
);
  localparam logic [ADDR_W-5:0] SW_PAGE = 12'hC00;

  always_comb begin
    strobe.flagWe  = busValid && busWrite && (busAddr[ADDR_W-1:4] == SW_PAGE);
    strobe.flagIdx = busAddr[FIDX_W:1];
    strobe.flagVal = busAddr[0];
  end

  // R1: a flag strobe only comes from a valid write cycle
  p_strobe_write_only_r1: assert property (@(posedge clk) disable iff (!rstN)
    strobe.flagWe |-> (busValid && busWrite));
endmodule

// File: rtl/router_datapath.sv
module router_datapath
  import router_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  swStrobe_t            strobe,
  input  logic                 busValid,
  input  logic                 busWrite,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic                 page2,
  input  logic                 hires,
  input  logic [DATA_W-1:0]    mainData,
  input  logic [DATA_W-1:0]    auxData,
  input  logic [DATA_W-1:0]    romData,
  input  logic [DATA_W-1:0]    slotData,
  output logic                 bankAux,
  output devSel_t              devSel,
  output logic [DATA_W-1:0]    rdData,
  output logic [NUM_FLAGS-1:0] flagsOut
);
  logic [NUM_FLAGS-1:0] flags;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) flags <= '0;
    else if (strobe.flagWe) flags[strobe.flagIdx] <= strobe.flagVal;
  end
  assign flagsOut = flags;

  // region decode
  logic isRam, isZp, isTxt, isHgr, isSwPage, isCx, isStat, cxShared;
  logic auxPick, statBit;

  always_comb begin
    isRam    = busAddr < 16'hC000;
    isZp     = busAddr[15:9] == '0;
    isTxt    = busAddr[15:10] == 6'b000001;
    isHgr    = busAddr[15:13] == 3'b001;
    isSwPage = busAddr[15:8] == 8'hC0;
    isCx     = (busAddr[15:12] == 4'hC) && (busAddr[11:8] != 4'h0) && (busAddr != 16'hCFFF);
    isStat   = isSwPage && (busAddr[7:4] == 4'h1) && (busAddr[3:0] >= 4'h3) && (busAddr[3:0] <= 4'h8);
    cxShared = (busAddr[11:8] == 4'h3) || busAddr[11];
  end

  always_comb begin
    if (isZp)                         auxPick = flags[F_ALTZP];
    else if (flags[F_STORE80] && isTxt) auxPick = page2;
    else if (flags[F_STORE80] && isHgr) auxPick = page2 && hires;
    else if (busWrite)                auxPick = flags[F_RAMWRT];
    else                              auxPick = flags[F_RAMRD];
  end

  always_comb begin
    case (busAddr[3:0])
      4'h3:    statBit = flags[F_RAMRD];
      4'h4:    statBit = flags[F_RAMWRT];
      4'h5:    statBit = flags[F_INTCX];
      4'h6:    statBit = flags[F_ALTZP];
      4'h7:    statBit = flags[F_SLOTC3];
      default: statBit = flags[F_STORE80];
    endcase
  end

  always_comb begin
    devSel  = DEV_NONE;
    bankAux = 1'b0;
    if (busValid) begin
      if (isRam) begin
        devSel  = DEV_RAM;
        bankAux = auxPick;
      end else if (isCx && !busWrite) begin
        if (flags[F_INTCX] || (cxShared && !flags[F_SLOTC3])) devSel = DEV_IROM;
        else                                                  devSel = DEV_SLOT;
      end else if (isStat && !busWrite) begin
        devSel = DEV_STAT;
      end
    end
  end

  always_comb begin
    rdData = '0;
    if (!busWrite) begin
      case (devSel)
        DEV_RAM:  rdData = bankAux ? auxData : mainData;
        DEV_IROM: rdData = romData;
        DEV_SLOT: rdData = slotData;
        DEV_STAT: rdData = {statBit, {(DATA_W-1){1'b0}}};
        default:  rdData = '0;
      endcase
    end
  end

  // R1: strobed flag takes the addressed value
  p_flag_update_r1: assert property (@(posedge clk) disable iff (!rstN)
    strobe.flagWe |=> flags[$past(strobe.flagIdx)] == $past(strobe.flagVal));
  // R1: without a strobe the flags hold
  p_flag_hold_r1: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.flagWe |=> $stable(flags));
  // R7: writes into the Cx window claim no device
  p_cx_write_ignored_r7: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && busWrite && busAddr >= 16'hC100 && busAddr <= 16'hCFFE) |-> devSel == DEV_NONE);
  // R8: status byte carries only bit 7
  p_status_low_zero_r8: assert property (@(posedge clk) disable iff (!rstN)
    devSel == DEV_STAT |-> rdData[DATA_W-2:0] == '0);
  // R9: flags are clear when reset ends
  p_reset_clear_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> flags == '0);
  // R10: bank select only with a RAM access
  p_bank_only_ram_r10: assert property (@(posedge clk) disable iff (!rstN)
    bankAux |-> devSel == DEV_RAM);
endmodule

// File: rtl/aux_bank_router.sv
module aux_bank_router
  import router_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [15:0]       busAddr,
  input  logic              page2,
  input  logic              hires,
  input  logic [7:0]        mainData,
  input  logic [7:0]        auxData,
  input  logic [7:0]        romData,
  input  logic [7:0]        slotData,
  output logic              bankAux,
  output logic [2:0]        devSel,
  output logic [7:0]        rdData,
  output logic [7:0]        flagsOut
);
  swStrobe_t strobe;
  devSel_t   devSelInt;

  router_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .strobe(strobe)
  );

  router_datapath u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .busValid(busValid),
    .busWrite(busWrite), .busAddr(busAddr), .page2(page2), .hires(hires),
    .mainData(mainData), .auxData(auxData), .romData(romData), .slotData(slotData),
    .bankAux(bankAux), .devSel(devSelInt), .rdData(rdData), .flagsOut(flagsOut)
  );

  assign devSel = devSelInt;
endmodule

// File: tb/sim_aux_bank_router.sv
module sim_aux_bank_router;
  logic clk = 0, rstN = 0, busValid = 0, busWrite = 0, page2 = 0, hires = 0;
  logic [15:0] busAddr = 0;
  logic [7:0] mainData = 8'h11, auxData = 8'h22, romData = 8'h33, slotData = 8'h44;
  logic bankAux;
  logic [2:0] devSel;
  logic [7:0] rdData, flagsOut;
  int checks = 0, failures = 0;

  always #5 clk = ~clk;

  aux_bank_router u0 (.*);

  // vector: [31:24] flags, [23] page2, [22] hires, [21] write, [20:5] addr, [4:2] dev, [1] aux
  function automatic logic [31:0] mk(input logic [7:0] f, input logic p, input logic h,
                                     input logic w, input logic [15:0] a,
                                     input logic [2:0] d, input logic x);
    return {f, p, h, w, a, d, x, 1'b0};
  endfunction

  localparam int NV = 14;
  localparam logic [31:0] VECS [NV] = '{
    mk(8'h10, 0, 0, 0, 16'h0080, 3'd1, 1), // R2
    mk(8'h06, 0, 0, 0, 16'h0100, 3'd1, 0), // R2
    mk(8'h02, 0, 0, 0, 16'h1000, 3'd1, 1), // R3
    mk(8'h02, 0, 0, 1, 16'h1000, 3'd1, 0), // R3
    mk(8'h04, 0, 0, 1, 16'h6000, 3'd1, 1), // R3
    mk(8'h03, 0, 0, 0, 16'h0400, 3'd1, 0), // R4
    mk(8'h01, 1, 0, 1, 16'h07FF, 3'd1, 1), // R4
    mk(8'h01, 1, 0, 0, 16'h2000, 3'd1, 0), // R5
    mk(8'h01, 1, 1, 1, 16'h3FFF, 3'd1, 1), // R5
    mk(8'h20, 0, 0, 0, 16'hC300, 3'd3, 0), // R6
    mk(8'h00, 0, 0, 0, 16'hC800, 3'd2, 0), // R6
    mk(8'h08, 0, 0, 0, 16'hC600, 3'd2, 0), // R6
    mk(8'h00, 0, 0, 1, 16'hC500, 3'd0, 0), // R7
    mk(8'h20, 0, 0, 0, 16'hC017, 3'd4, 0)  // R8
  };

  // reference routing from the requirements: {dev, aux}
  function automatic logic [3:0] refRoute(input logic [15:0] a, input logic w,
                                          input logic [7:0] f, input logic p, input logic h);
    logic x;
    if (a < 16'hC000) begin
      if (a < 16'h0200) x = f[4];
      else if (f[0] && a >= 16'h0400 && a < 16'h0800) x = p;
      else if (f[0] && a >= 16'h2000 && a < 16'h4000) x = p & h;
      else x = w ? f[2] : f[1];
      return {3'd1, x};
    end
    if (a >= 16'hC013 && a <= 16'hC018) return w ? 4'd0 : {3'd4, 1'b0};
    if (a >= 16'hC100 && a <= 16'hCFFE) begin
      if (w) return 4'd0;
      if (f[3]) return {3'd2, 1'b0};
      if (!f[5] && ((a >= 16'hC300 && a < 16'hC400) || a >= 16'hC800)) return {3'd2, 1'b0};
      return {3'd3, 1'b0};
    end
    return 4'd0;
  endfunction

  function automatic logic [7:0] refData(input logic [3:0] r, input logic [15:0] a,
                                         input logic w, input logic [7:0] f);
    logic b;
    if (w) return 8'h00;
    case (r[3:1])
      3'd1: return r[0] ? 8'h22 : 8'h11;
      3'd2: return 8'h33;
      3'd3: return 8'h44;
      3'd4: begin
        case (a)
          16'hC013: b = f[1];
          16'hC014: b = f[2];
          16'hC015: b = f[3];
          16'hC016: b = f[4];
          16'hC017: b = f[5];
          default:  b = f[0];
        endcase
        return {b, 7'd0};
      end
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic setFlags(input logic [7:0] f);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      busValid = 1; busWrite = 1; busAddr = 16'hC000 + 16'(2 * i) + 16'(f[i]);
      @(posedge clk);
    end
    @(negedge clk);
    busValid = 0; busWrite = 0;
  endtask

  task automatic access(input string tag, input logic [15:0] a, input logic w,
                        input logic [7:0] f, input logic p, input logic h);
    logic [3:0] r;
    busValid = 1; busWrite = w; busAddr = a; page2 = p; hires = h;
    #1;
    r = refRoute(a, w, f, p, h);
    chk(tag, {28'd0, devSel, bankAux}, {28'd0, r});
    chk({tag, " R11"}, {24'd0, rdData}, {24'd0, refData(r, a, w, f)});
    busValid = 0; busWrite = 0;
    #1;
  endtask

  localparam int NA = 18;
  localparam logic [15:0] ADDRS [NA] = '{
    16'h0050, 16'h01FF, 16'h0200, 16'h0400, 16'h07FF, 16'h0800, 16'h2000, 16'h3FFF,
    16'h4000, 16'hBFFF, 16'hC100, 16'hC300, 16'hC3FF, 16'hC800, 16'hCFFE, 16'hCFFF,
    16'hC013, 16'hD000
  };

  initial begin
    fork
      begin
        #5_000_000;
        failures++; checks++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    join_none

    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1;
    #1;
    chk("R9 reset flags", {24'd0, flagsOut}, 32'd0);
    access("R9 reset status", 16'hC018, 0, 8'h00, 0, 0);
    access("R10 idle", 16'h1000, 0, 8'h00, 0, 0);

    // R10: no valid strobe means no device
    busAddr = 16'h0100; busWrite = 0; busValid = 0; #1;
    chk("R10 invalid", {29'd0, devSel}, 32'd0);

    // table walk
    for (int v = 0; v < NV; v++) begin
      logic [31:0] e;
      e = VECS[v];
      setFlags(e[31:24]);
      busValid = 1; busWrite = e[21]; busAddr = e[20:5]; page2 = e[23]; hires = e[22];
      #1;
      chk($sformatf("table vec %0d", v), {28'd0, devSel, bankAux}, {28'd0, e[4:1]});
      busValid = 0; busWrite = 0; #1;
    end

    // R1: col80 and altChar set and clear, write data ignored
    setFlags(8'hC0);
    chk("R1 set upper", {24'd0, flagsOut}, 32'h000000C0);
    setFlags(8'h40);
    chk("R1 clear altChar", {24'd0, flagsOut}, 32'h00000040);

    // R7: writes into Cx window leave flags and are not claimed
    setFlags(8'h2A);
    @(negedge clk); busValid = 1; busWrite = 1; busAddr = 16'hC00F; busValid = 0;
    busValid = 1; busAddr = 16'hC200; @(posedge clk); @(negedge clk);
    busAddr = 16'hCFFE; @(posedge clk); @(negedge clk);
    busValid = 0; busWrite = 0; #1;
    chk("R7 flags unchanged", {24'd0, flagsOut}, 32'h0000002A);
    // R1: read of a switch address does not change flags
    busValid = 1; busAddr = 16'hC001; @(posedge clk); @(negedge clk); busValid = 0; #1;
    chk("R1 read no effect", {24'd0, flagsOut}, 32'h0000002A);

    // R8: each status address under one-hot flags
    for (int b = 0; b < 6; b++) begin
      logic [7:0] f;
      f = 8'(1 << b);
      setFlags(f);
      for (int s = 3; s <= 8; s++) access("R8 status", 16'hC010 + 16'(s), 0, f, 0, 0);
    end

    // sweep: R2 R3 R4 R5 R6 R10 against reference
    for (int fi = 0; fi < 64; fi++) begin
      setFlags(8'(fi));
      for (int ph = 0; ph < 4; ph++)
        for (int ai = 0; ai < NA; ai++)
          for (int w = 0; w < 2; w++)
            access("sweep R2 R3 R4 R5 R6 R10", ADDRS[ai], w[0], 8'(fi), ph[1], ph[0]);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule